// File: doc/BRIEF.md
# Local Interrupt Acceptance Unit

This unit sits beside one processor core and receives interrupt messages, each carrying an 8-bit vector and a trigger-mode flag. A message that is accepted sets the vector's bit in a 256-bit pending set and records its trigger mode. Every cycle the unit looks at the highest pending vector. It offers that vector to the core only when the vector's priority class (vector bits 7:4) is above the class held in the task priority register and above the class of the highest vector already in service. When the core takes the offer, the vector moves from the pending set to the in-service set.

Software ends an interrupt by writing to the end-of-interrupt register. This retires the highest in-service vector. For level-triggered vectors the unit then sends out a one-cycle strobe carrying that vector, so the upstream redirection logic can re-sample the line. A simple 32-bit register bus with zero-latency reads gives access to the version, the task priority, the software enable with the spurious vector, and the three 256-bit sets, split into 32-bit windows.

Top module: `lirq_accept`

## Requirements
- R1: After reset the pending, in-service and trigger-mode sets are all zero, the task priority is 0x00, the software enable is clear, the spurious vector reads 0xFF, core_irq is low and eoi_strobe is low.
- R2: A read of offset 0x030 returns 0x00000014. Writes to this offset have no effect.
- R3: Offset 0x0F0 holds the spurious vector in bits 7:0 and the software enable in bit 8. Bits 3:0 always read as 1 whatever was written, and bits 31:9 read as 0.
- R4: While the enable bit is clear, incoming messages are dropped. Messages whose vector is 0x00 to 0x0F are always dropped.
- R5: An accepted message sets its bit in the pending set and writes its trigger-mode bit (1 = level, 0 = edge) into the trigger-mode set, one cycle later. If the pending bit is already set, the new message merges into it. The pending set reads at 0x200 + 4k and the trigger-mode set at 0x180 + 4k, where window k holds vectors 32k to 32k+31, with vector 32k in bit 0.
- R6: core_irq is high, with core_vec equal to the highest pending vector, exactly when that vector's bits 7:4 exceed bits 7:4 of the task priority (offset 0x080, bits 7:0) and also exceed bits 7:4 of the highest in-service vector (taken as 0 when nothing is in service).
- R7: When core_take is high in a cycle where core_irq is high, the vector's pending bit clears and its in-service bit sets at the same clock edge. The in-service set reads at 0x100 + 4k. core_take has no effect while core_irq is low.
- R8: Any write to offset 0x0B0, whatever the data, clears the highest set bit of the in-service set. When nothing is in service, the write changes nothing.
- R9: One cycle after an end-of-interrupt write, eoi_strobe is high for one cycle with eoi_vector equal to the retired vector. This happens only if that vector's trigger-mode bit was set.
- R10: If a message for a vector arrives in the same cycle the vector is delivered, the pending bit stays set. If a delivery and an end-of-interrupt write fall in the same cycle, the write retires the in-service vector that was highest before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | Interrupt message present this cycle |
| msg_vector | input | 8 | Vector of the incoming message |
| msg_level | input | 1 | Trigger mode of the message, 1 = level |
| core_take | input | 1 | Core accepts the offered vector |
| core_irq | output | 1 | A vector is offered to the core |
| core_vec | output | 8 | Offered vector |
| eoi_strobe | output | 1 | End-of-interrupt notice for a level vector |
| eoi_vector | output | 8 | Vector carried by eoi_strobe |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, same cycle |

## Verification
A wrong bit in the pending or in-service set shows up within one cycle as a wrong core_irq or core_vec, because both come combinationally from those sets. It is also visible at once through the 32-bit windows. A trigger-mode bit that was lost only shows up later, at the end-of-interrupt write that retires that vector: the strobe is then missing or appears when it should not. For this reason the stimulus keeps retiring vectors of both trigger modes. The bench also aims at the same-cycle collisions of message with delivery and of delivery with end-of-interrupt. These are the places where the order of set and clear decides the state of the sets.

// File: rtl/lirq_pkg.sv
package lirq_pkg;
  // register offsets (byte addresses on the register bus)
  localparam logic [11:0] OFF_VER = 12'h030;
  localparam logic [11:0] OFF_TPR = 12'h080;
  localparam logic [11:0] OFF_EOI = 12'h0B0;
  localparam logic [11:0] OFF_SVR = 12'h0F0;
  localparam logic [11:0] OFF_ISR = 12'h100;
  localparam logic [11:0] OFF_TMR = 12'h180;
  localparam logic [11:0] OFF_IRR = 12'h200;
  // width of the priority class field at the top of a vector
  localparam int CLS_W = 4;
  // spurious vector reset value
  localparam logic [7:0] SVR_RESET = 8'hFF;
endpackage

// File: rtl/lirq_bitvec.sv
module lirq_bitvec #(
  parameter int WIDTH = 256,
  localparam int IW = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [IW-1:0]    set_idx,
  input  logic             set_val,
  input  logic             clr_en,
  input  logic [IW-1:0]    clr_idx,
  output logic [WIDTH-1:0] bits_q
);
  logic [WIDTH-1:0] bits_d;

  // clear first, set second: a set on the same index wins
  always_comb begin
    bits_d = bits_q;
    if (clr_en) bits_d[clr_idx] = 1'b0;
    if (set_en) bits_d[set_idx] = set_val;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bits_q <= '0;
    else        bits_q <= bits_d;
  end

  // R5: a write lands at the addressed bit one cycle later
  p_set_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> (bits_q[$past(set_idx)] == $past(set_val)));

  // R7 and R8: a clear without a colliding set leaves the bit low
  p_clear_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !(set_en && set_idx == clr_idx)) |=> !bits_q[$past(clr_idx)]);
endmodule

// File: rtl/lirq_prio_gate.sv
module lirq_prio_gate
  import lirq_pkg::*;
#(
  parameter int WIDTH = 256,
  localparam int IW = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] irr_bits,
  input  logic [WIDTH-1:0] isr_bits,
  input  logic [IW-1:0]    tpr,
  output logic             irr_any,
  output logic [IW-1:0]    irr_top,
  output logic             isr_any,
  output logic [IW-1:0]    isr_top,
  output logic             deliver_ok
);
  // highest set bit; result MSB flags that any bit was set
  function automatic logic [IW:0] find_top(input logic [WIDTH-1:0] v);
    logic [IW:0] r;
    r = '0;
    for (int i = 0; i < WIDTH; i++)
      if (v[i]) r = {1'b1, IW'(i)};
    return r;
  endfunction

  function automatic logic [CLS_W-1:0] class_of(input logic [IW-1:0] v);
    return v[IW-1 -: CLS_W];
  endfunction

  logic [IW:0] irr_f, isr_f;
  logic [CLS_W-1:0] pend_cls, svc_cls, tpr_cls;
  logic unused_tpr_low;

  assign irr_f    = find_top(irr_bits);
  assign isr_f    = find_top(isr_bits);
  assign irr_any  = irr_f[IW];
  assign irr_top  = irr_f[IW-1:0];
  assign isr_any  = isr_f[IW];
  assign isr_top  = isr_f[IW-1:0];
  assign pend_cls = class_of(irr_top);
  assign svc_cls  = isr_any ? class_of(isr_top) : '0;
  assign tpr_cls  = class_of(tpr);
  assign unused_tpr_low = ^tpr[IW-CLS_W-1:0];

  assign deliver_ok = irr_any && (pend_cls > tpr_cls) && (pend_cls > svc_cls);
endmodule

// File: rtl/lirq_regif.sv
module lirq_regif
  import lirq_pkg::*;
#(
  parameter int NUM_VEC = 256,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 12,
  parameter logic [7:0] VERSION_ID = 8'h14,
  localparam int VW = $clog2(NUM_VEC),
  localparam int NCHUNK = NUM_VEC / DATA_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  input  logic [NUM_VEC-1:0] irr_bits,
  input  logic [NUM_VEC-1:0] isr_bits,
  input  logic [NUM_VEC-1:0] tmr_bits,
  output logic [VW-1:0]      tpr_q,
  output logic               sw_enable,
  output logic [VW-1:0]      spur_vec,
  output logic               eoi_wr,
  output logic [DATA_W-1:0]  reg_rdata
);
  localparam int BYTES = DATA_W / 8;

  logic hit_ver, hit_tpr, hit_eoi, hit_svr;
  logic [NCHUNK-1:0] hit_isr, hit_tmr, hit_irr;
  logic [VW-CLS_W-1:0] spur_hi_q;
  logic unused_wbits;

  assign hit_ver = (reg_addr == ADDR_W'(OFF_VER));
  assign hit_tpr = (reg_addr == ADDR_W'(OFF_TPR));
  assign hit_eoi = (reg_addr == ADDR_W'(OFF_EOI));
  assign hit_svr = (reg_addr == ADDR_W'(OFF_SVR));

  for (genvar k = 0; k < NCHUNK; k++) begin : g_win
    assign hit_isr[k] = (reg_addr == ADDR_W'(int'(OFF_ISR) + k * BYTES));
    assign hit_tmr[k] = (reg_addr == ADDR_W'(int'(OFF_TMR) + k * BYTES));
    assign hit_irr[k] = (reg_addr == ADDR_W'(int'(OFF_IRR) + k * BYTES));
  end

  assign eoi_wr   = reg_wr && hit_eoi;
  assign spur_vec = {spur_hi_q, {CLS_W{1'b1}}};
  assign unused_wbits = ^{reg_wdata[DATA_W-1:VW+1], reg_wdata[CLS_W-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tpr_q     <= '0;
      sw_enable <= 1'b0;
      spur_hi_q <= SVR_RESET[7 -: (VW-CLS_W)];
    end else if (reg_wr) begin
      if (hit_tpr) tpr_q <= reg_wdata[VW-1:0];
      if (hit_svr) begin
        sw_enable <= reg_wdata[VW];
        spur_hi_q <= reg_wdata[VW-1:CLS_W];
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (hit_ver) reg_rdata = DATA_W'(VERSION_ID);
    if (hit_tpr) reg_rdata = DATA_W'(tpr_q);
    if (hit_svr) reg_rdata = DATA_W'({sw_enable, spur_vec});
    for (int k = 0; k < NCHUNK; k++) begin
      if (hit_isr[k]) reg_rdata = isr_bits[k*DATA_W +: DATA_W];
      if (hit_tmr[k]) reg_rdata = tmr_bits[k*DATA_W +: DATA_W];
      if (hit_irr[k]) reg_rdata = irr_bits[k*DATA_W +: DATA_W];
    end
  end

  // R6: a priority write is visible the next cycle
  p_tpr_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && hit_tpr) |=> (tpr_q == $past(reg_wdata[VW-1:0])));

  // R3: an enable write reaches the enable flop
  p_enable_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && hit_svr) |=> (sw_enable == $past(reg_wdata[VW])));

  // R2: version register never changes
  p_version_fixed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hit_ver |-> (reg_rdata[7:0] == VERSION_ID));
endmodule

// File: rtl/lirq_accept.sv
module lirq_accept
  import lirq_pkg::*;
#(
  parameter int NUM_VEC = 256,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 12,
  parameter logic [7:0] VERSION_ID = 8'h14,
  localparam int VW = $clog2(NUM_VEC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              msg_valid,
  input  logic [VW-1:0]     msg_vector,
  input  logic              msg_level,
  input  logic              core_take,
  output logic              core_irq,
  output logic [VW-1:0]     core_vec,
  output logic              eoi_strobe,
  output logic [VW-1:0]     eoi_vector,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata
);
  logic [NUM_VEC-1:0] irr_bits, isr_bits, tmr_bits;
  logic [VW-1:0] tpr_q, spur_vec, irr_top, isr_top;
  logic sw_enable, eoi_wr, irr_any, isr_any, deliver_ok;
  // named events for the assertions
  logic msg_accept, deliver_fire, eoi_fire;
  logic eoi_strobe_q;
  logic [VW-1:0] eoi_vec_q;
  logic unused_spur;

  assign msg_accept   = msg_valid && sw_enable && (msg_vector[VW-1 -: CLS_W] != '0);
  assign deliver_fire = core_take && deliver_ok;
  assign eoi_fire     = eoi_wr && isr_any;
  assign unused_spur  = ^spur_vec;

  lirq_regif #(.NUM_VEC(NUM_VEC), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
               .VERSION_ID(VERSION_ID)) u_regif (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .irr_bits(irr_bits), .isr_bits(isr_bits),
    .tmr_bits(tmr_bits), .tpr_q(tpr_q), .sw_enable(sw_enable),
    .spur_vec(spur_vec), .eoi_wr(eoi_wr), .reg_rdata(reg_rdata));

  lirq_bitvec #(.WIDTH(NUM_VEC)) u_irr (
    .clk(clk), .rst_n(rst_n),
    .set_en(msg_accept), .set_idx(msg_vector), .set_val(1'b1),
    .clr_en(deliver_fire), .clr_idx(irr_top), .bits_q(irr_bits));

  lirq_bitvec #(.WIDTH(NUM_VEC)) u_isr (
    .clk(clk), .rst_n(rst_n),
    .set_en(deliver_fire), .set_idx(irr_top), .set_val(1'b1),
    .clr_en(eoi_fire), .clr_idx(isr_top), .bits_q(isr_bits));

  lirq_bitvec #(.WIDTH(NUM_VEC)) u_tmr (
    .clk(clk), .rst_n(rst_n),
    .set_en(msg_accept), .set_idx(msg_vector), .set_val(msg_level),
    .clr_en(1'b0), .clr_idx('0), .bits_q(tmr_bits));

  lirq_prio_gate #(.WIDTH(NUM_VEC)) u_gate (
    .irr_bits(irr_bits), .isr_bits(isr_bits), .tpr(tpr_q),
    .irr_any(irr_any), .irr_top(irr_top), .isr_any(isr_any),
    .isr_top(isr_top), .deliver_ok(deliver_ok));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eoi_strobe_q <= 1'b0;
      eoi_vec_q    <= '0;
    end else begin
      eoi_strobe_q <= eoi_fire && tmr_bits[isr_top];
      if (eoi_fire) eoi_vec_q <= isr_top;
    end
  end

  assign core_irq   = deliver_ok;
  assign core_vec   = irr_top;
  assign eoi_strobe = eoi_strobe_q;
  assign eoi_vector = eoi_vec_q;

  // R6: an offered vector always beats the task priority class
  p_irq_above_tpr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    core_irq |-> (core_vec[VW-1 -: CLS_W] > tpr_q[VW-1 -: CLS_W]));

  // R7: a taken offer lands in the in-service set
  p_take_moves_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (core_irq && core_take) |=> isr_bits[$past(core_vec)]);

  // R4: nothing enters the pending set while disabled
  p_disabled_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !sw_enable && !irr_bits[msg_vector]) |=> !irr_bits[$past(msg_vector)]);

  // R4: class-zero vectors never become pending
  p_low_vec_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_vector[VW-1 -: CLS_W] == '0 && !irr_bits[msg_vector])
      |=> !irr_bits[$past(msg_vector)]);

  // R9: a strobe only follows an end-of-interrupt write
  p_eoi_from_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_strobe |-> $past(eoi_wr));

  // R8: the retired vector leaves the in-service set
  p_eoi_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_fire |=> !isr_bits[$past(isr_top)]);
endmodule

// File: tb/lirq_accept_bench.sv
module lirq_accept_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic msg_valid = 1'b0;
  logic [7:0] msg_vector = '0;
  logic msg_level = 1'b0;
  logic core_take = 1'b0;
  logic core_irq, eoi_strobe;
  logic [7:0] core_vec, eoi_vector;
  logic reg_wr = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;

  int n_checks = 0;
  int n_fails = 0;
  bit done = 0;

  // model state
  logic [255:0] m_irr, m_isr, m_tmr;
  logic [7:0] m_tpr, m_svec;
  logic m_en, m_eoi;
  logic [7:0] m_eoi_vec;

  always #(CLK_PERIOD/2) clk = ~clk;

  lirq_accept u_lirq_accept (
    .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_vector(msg_vector),
    .msg_level(msg_level), .core_take(core_take), .core_irq(core_irq),
    .core_vec(core_vec), .eoi_strobe(eoi_strobe), .eoi_vector(eoi_vector),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata));

  function automatic int top_of(input logic [255:0] b);
    for (int i = 255; i >= 0; i--) if (b[i]) return i;
    return -1;
  endfunction

  function automatic logic model_irq();
    int h, s;
    h = top_of(m_irr);
    s = top_of(m_isr);
    if (h < 0) return 1'b0;
    if ((h / 16) <= int'(m_tpr[7:4])) return 1'b0;
    if (s >= 0 && (h / 16) <= (s / 16)) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic [31:0] model_read(input logic [11:0] a);
    int w;
    if (a == 12'h030) return 32'h14;
    if (a == 12'h080) return {24'h0, m_tpr};
    if (a == 12'h0F0) return {23'h0, m_en, m_svec};
    if (a >= 12'h100 && a < 12'h120 && a[1:0] == 2'b00) begin
      w = (int'(a) - 'h100) / 4; return m_isr[w*32 +: 32];
    end
    if (a >= 12'h180 && a < 12'h1A0 && a[1:0] == 2'b00) begin
      w = (int'(a) - 'h180) / 4; return m_tmr[w*32 +: 32];
    end
    if (a >= 12'h200 && a < 12'h220 && a[1:0] == 2'b00) begin
      w = (int'(a) - 'h200) / 4; return m_irr[w*32 +: 32];
    end
    return 32'h0;
  endfunction

  function automatic string tag_for(input logic [11:0] a);
    if (a == 12'h030) return "R2";
    if (a == 12'h0F0) return "R3";
    if (a == 12'h080) return "R6";
    if (a >= 12'h100 && a < 12'h120) return "R7";
    if (a >= 12'h180 && a < 12'h220) return "R5";
    return "R8";
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_irr = '0; m_isr = '0; m_tmr = '0;
    m_tpr = 8'h00; m_svec = 8'hFF; m_en = 1'b0;
    m_eoi = 1'b0; m_eoi_vec = 8'h00;
  endtask

  // state change at a clock edge, from the inputs held during the cycle
  task automatic model_edge();
    logic acc, dlv, eoi;
    int h, s;
    h = top_of(m_irr);
    s = top_of(m_isr);
    acc = msg_valid && m_en && (msg_vector[7:4] != 4'h0);
    dlv = core_take && model_irq();
    eoi = reg_wr && reg_addr == 12'h0B0;
    m_eoi = eoi && (s >= 0) && m_tmr[s];
    if (eoi && s >= 0) m_eoi_vec = 8'(s);
    if (dlv) m_irr[h] = 1'b0;
    if (acc) begin m_irr[msg_vector] = 1'b1; m_tmr[msg_vector] = msg_level; end
    if (eoi && s >= 0) m_isr[s] = 1'b0;
    if (dlv) m_isr[h] = 1'b1;
    if (reg_wr && reg_addr == 12'h080) m_tpr = reg_wdata[7:0];
    if (reg_wr && reg_addr == 12'h0F0) begin
      m_en = reg_wdata[8]; m_svec = {reg_wdata[7:4], 4'hF};
    end
  endtask

  // called just after a falling edge with the inputs already set
  task automatic tick(input string rtag);
    #1;
    chk(rtag, reg_rdata, model_read(reg_addr));
    chk("R6", {31'h0, core_irq}, {31'h0, model_irq()});
    if (model_irq()) chk("R6", {24'h0, core_vec}, {24'h0, 8'(top_of(m_irr))});
    chk("R9", {31'h0, eoi_strobe}, {31'h0, m_eoi});
    if (m_eoi) chk("R9", {24'h0, eoi_vector}, {24'h0, m_eoi_vec});
    @(posedge clk);
    model_edge();
    @(negedge clk);
    msg_valid = 1'b0; core_take = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic send(input logic [7:0] v, input logic lvl, input logic [11:0] ra, input string t);
    msg_valid = 1'b1; msg_vector = v; msg_level = lvl; reg_addr = ra;
    tick(t);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input string t);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick(t);
  endtask

  task automatic look(input logic [11:0] a, input string t);
    reg_addr = a;
    tick(t);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    logic [11:0] addrs [0:27];
    int r, w;
    void'($urandom(32'h5A17));
    addrs[0] = 12'h030; addrs[1] = 12'h080; addrs[2] = 12'h0F0; addrs[3] = 12'h0B0;
    for (int k = 0; k < 8; k++) begin
      addrs[4 + k]  = 12'(12'h100 + 4 * k);
      addrs[12 + k] = 12'(12'h180 + 4 * k);
      addrs[20 + k] = 12'(12'h200 + 4 * k);
    end
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: state after reset
    look(12'h0F0, "R1");
    look(12'h080, "R1");
    look(12'h200, "R1");
    look(12'h100, "R1");
    look(12'h030, "R2");
    wr(12'h030, 32'hFFFF_FFFF, "R2");
    look(12'h030, "R2");

    // R4: disabled unit drops messages
    send(8'h45, 1'b1, 12'h208, "R4");
    look(12'h208, "R4");

    // R3: enable, low nibble forced to ones, upper bits read zero
    wr(12'h0F0, 32'hFFFF_FE30, "R3");
    look(12'h0F0, "R3");
    wr(12'h0F0, 32'h0000_0130, "R3");
    look(12'h0F0, "R3");

    // R4: class-zero vector dropped even when enabled
    send(8'h0A, 1'b1, 12'h200, "R4");
    look(12'h200, "R4");

    // R6: full block, then R5 merge with trigger mode update
    wr(12'h080, 32'hFF, "R6");
    send(8'h45, 1'b0, 12'h208, "R5");
    send(8'h45, 1'b1, 12'h208, "R5");
    look(12'h188, "R5");
    look(12'h208, "R5");

    // R6: equal class blocked, lower class passes
    wr(12'h080, 32'h40, "R6");
    look(12'h080, "R6");
    wr(12'h080, 32'h3F, "R6");
    look(12'h208, "R6");

    // R7: take moves pending to in-service
    core_take = 1'b1; reg_addr = 12'h108; tick("R7");
    look(12'h108, "R7");
    look(12'h208, "R7");
    // R6: same class as in-service is held back
    send(8'h47, 1'b0, 12'h208, "R6");
    look(12'h208, "R6");
    // R7: take without offer has no effect
    core_take = 1'b1; reg_addr = 12'h108; tick("R7");

    // R10: higher class delivered while a message for it arrives
    send(8'h90, 1'b0, 12'h210, "R5");
    msg_valid = 1'b1; msg_vector = 8'h90; msg_level = 1'b0; core_take = 1'b1;
    reg_addr = 12'h210; tick("R10");
    look(12'h210, "R10");
    look(12'h110, "R10");

    // R8/R9: retire edge vector 0x90 (no strobe), then level 0x45 (strobe)
    wr(12'h0B0, 32'h0, "R8");
    look(12'h110, "R8");
    wr(12'h0B0, 32'hDEAD_BEEF, "R9");
    look(12'h108, "R9");
    // R10: delivery and end-of-interrupt in the same cycle
    core_take = 1'b1; reg_wr = 1'b1; reg_addr = 12'h0B0; reg_wdata = 0; tick("R10");
    look(12'h110, "R10");
    look(12'h108, "R10");
    // R8: drain then write with nothing in service
    for (int i = 0; i < 4; i++) wr(12'h0B0, 32'h0, "R8");
    look(12'h110, "R8");

    // constrained random phase
    for (int c = 0; c < 4000; c++) begin
      r = $urandom_range(0, 99);
      msg_valid = (r < 55);
      msg_vector = 8'($urandom_range(0, 255));
      msg_level = 1'($urandom_range(0, 1));
      core_take = 1'($urandom_range(0, 1));
      w = $urandom_range(0, 99);
      if (w < 14) begin
        reg_wr = 1'b1; reg_addr = 12'h0B0; reg_wdata = $urandom;
      end else if (w < 17) begin
        reg_wr = 1'b1; reg_addr = 12'h080;
        case ($urandom_range(0, 4))
          0: reg_wdata = 32'h00;
          1: reg_wdata = 32'h2C;
          2: reg_wdata = 32'h57;
          3: reg_wdata = 32'h90;
          default: reg_wdata = 32'hFF;
        endcase
      end else if (w < 18) begin
        reg_wr = 1'b1; reg_addr = 12'h0F0;
        reg_wdata = {$urandom} & 32'hFFFF_FEFF;
        if ($urandom_range(0, 4) != 0) reg_wdata[8] = 1'b1;
      end else begin
        reg_addr = addrs[$urandom_range(0, 27)];
      end
      tick(tag_for(reg_addr));
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule